// File: doc/BRIEF.md
# Addressable Scan Cell Array

This block holds the sixteen state bits of a small circuit under test and makes each bit individually reachable in test mode. Instead of moving all bits through one long serial chain, the tester loads the binary address of one cell into an address shift register, one bit per clock. The upper address bits pick a row and the lower bits pick a column. A write strobe then stores the scan data input into that cell only, and a registered scan output shows the content of the addressed cell.

In normal mode the array acts as the circuit's ordinary state register: a capture pulse loads all cells from the parallel next-state inputs at once, and the address path plays no part. The address register is not cleared between operations. A tester can therefore reach a new cell by shifting in only the bits that differ from the old address, and can apply a new pattern by writing only the cells whose value must change.

Top module: `ras_array`

## Requirements
- R1: After reset every cell holds 0, the address register holds 0 and `scan_do` is 0.
- R2: While `test_mode` and `addr_shift` are both 1, each rising clock edge moves the address register one place toward its MSB and loads `addr_si` into bit 0. The address is {row, column}, with the row in the upper two bits and the column in the lower two bits, and the cell index is row*4 + column (bit `index` of `state_q`).
- R3: When `addr_shift` is 0, or `test_mode` is 0, the address register keeps its value.
- R4: The row decode and the column decode each select one line from their own address bits, and together they enable at most one cell per cycle.
- R5: While `test_mode` and `scan_wr` are both 1, a rising clock edge stores `scan_di` into the addressed cell, and every other cell keeps its value.
- R6: `scan_do` is registered: after each rising edge it shows the value that the addressed cell held just before that edge.
- R7: While `test_mode` is 0 and `capture` is 1, a rising edge loads all cells from `next_state` at once, whatever the address register holds.
- R8: The cells hold their values when neither a write (R5) nor a capture (R7) applies: `scan_wr` has no effect in normal mode, and `capture` has no effect in test mode.
- R9: Because the address persists, shifting k new bits leaves the old low-order bits in the upper positions, so address 5 (0101) becomes 11 (1011) after one shift of a 1.
- R10: A new pattern is applied by writing only the cells whose value differs from the current state; after that number of writes, equal to the Hamming distance, `state_q` equals the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_mode | input | 1 | 1 selects addressed scan access, 0 selects normal operation |
| addr_shift | input | 1 | Shift enable for the address register |
| addr_si | input | 1 | Serial address bit, entered at the LSB |
| scan_wr | input | 1 | Write strobe for the addressed cell |
| scan_di | input | 1 | Data written into the addressed cell |
| scan_do | output | 1 | Registered value of the addressed cell |
| capture | input | 1 | Parallel load of all cells in normal mode |
| next_state | input | 16 | Parallel next-state values from the logic |
| state_q | output | 16 | Current cell values to the logic |

## Verification
On every cycle, assertions check that the address register shifts or holds as commanded, that no more than one cell is enabled, that a write changes at most one cell, that a capture copies `next_state` exactly, that a hold leaves the array untouched, and that `scan_do` follows the previously addressed cell. Only the bench scenarios show that the correct cell is the one written for a given address, that a partial address shift lands on the expected cell, and that a pattern applied through a minimal set of writes ends with the right state. The bench also shows that the strobe in the wrong mode has no effect when the result is observed at the ports.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_WRITE   = 2'd2
  } ras_op_e;

  function automatic ras_op_e ras_decode_op(input logic test_mode,
                                            input logic scan_wr,
                                            input logic capture);
    if (test_mode) return scan_wr ? OP_WRITE : OP_HOLD;
    else           return capture ? OP_CAPTURE : OP_HOLD;
  endfunction

endpackage

// File: rtl/ras_addr_sr.sv
module ras_addr_sr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              serial_in,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (shift_en) addr_d = {addr_q[ADDR_W-2:0], serial_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assert_addr_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (addr_q[0] == $past(serial_in)) &&
                 (addr_q[ADDR_W-1:1] == $past(addr_q[ADDR_W-2:0])));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(addr_q));

endmodule

// File: rtl/ras_line_dec.sv
module ras_line_dec #(
  parameter int IN_W  = 2,
  parameter int OUT_N = 4
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] sel
);

  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign sel[i] = (code == IN_W'(i));
  end

endmodule

// File: rtl/ras_cell_array.sv
module ras_cell_array
  import ras_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  localparam int NUM_CELLS = NUM_ROWS * NUM_COLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ras_op_e              op,
  input  logic [NUM_ROWS-1:0]  row_sel,
  input  logic [NUM_COLS-1:0]  col_sel,
  input  logic                 wr_data,
  input  logic [NUM_CELLS-1:0] par_d,
  output logic [NUM_CELLS-1:0] cell_sel,
  output logic [NUM_CELLS-1:0] cell_q
);

  logic [NUM_CELLS-1:0] cell_we;
  logic [NUM_CELLS-1:0] cell_d;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      localparam int IDX = r * NUM_COLS + c;
      assign cell_sel[IDX] = row_sel[r] & col_sel[c];
      assign cell_we[IDX]  = cell_sel[IDX] & (op == OP_WRITE);

      always_comb begin
        cell_d[IDX] = cell_q[IDX];
        if (op == OP_CAPTURE)  cell_d[IDX] = par_d[IDX];
        else if (cell_we[IDX]) cell_d[IDX] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= '0;
    else        cell_q <= cell_d;
  end

  assert_single_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we));

  assert_write_one_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> ($countones(cell_q ^ $past(cell_q)) <= 1));

  assert_capture_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CAPTURE) |=> (cell_q == $past(par_d)));

  assert_hold_cells_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(cell_q));

endmodule

// File: rtl/ras_read_port.sv
module ras_read_port #(
  parameter int NUM_CELLS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CELLS-1:0] cell_sel,
  input  logic [NUM_CELLS-1:0] cell_q,
  output logic                 rd_q
);

  logic rd_d;

  always_comb rd_d = |(cell_sel & cell_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end

endmodule

// File: rtl/ras_array.sv
module ras_array
  import ras_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W    = ROW_BITS + COL_BITS,
  localparam int NUM_ROWS  = 1 << ROW_BITS,
  localparam int NUM_COLS  = 1 << COL_BITS,
  localparam int NUM_CELLS = NUM_ROWS * NUM_COLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 test_mode,
  input  logic                 addr_shift,
  input  logic                 addr_si,
  input  logic                 scan_wr,
  input  logic                 scan_di,
  output logic                 scan_do,
  input  logic                 capture,
  input  logic [NUM_CELLS-1:0] next_state,
  output logic [NUM_CELLS-1:0] state_q
);

  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_ROWS-1:0]  row_sel;
  logic [NUM_COLS-1:0]  col_sel;
  logic [NUM_CELLS-1:0] cell_sel;
  ras_op_e              op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign op = ras_decode_op(test_mode, scan_wr, capture);

  ras_addr_sr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .shift_en  (test_mode & addr_shift),
    .serial_in (addr_si),
    .addr_q    (addr_q)
  );

  ras_line_dec #(.IN_W(ROW_BITS), .OUT_N(NUM_ROWS)) u_row_dec (
    .code (addr_q[ADDR_W-1:COL_BITS]),
    .sel  (row_sel)
  );

  ras_line_dec #(.IN_W(COL_BITS), .OUT_N(NUM_COLS)) u_col_dec (
    .code (addr_q[COL_BITS-1:0]),
    .sel  (col_sel)
  );

  ras_cell_array #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_cells (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .op       (op),
    .row_sel  (row_sel),
    .col_sel  (col_sel),
    .wr_data  (scan_di),
    .par_d    (next_state),
    .cell_sel (cell_sel),
    .cell_q   (state_q)
  );

  ras_read_port #(.NUM_CELLS(NUM_CELLS)) u_read (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cell_sel (cell_sel),
    .cell_q   (state_q),
    .rd_q     (scan_do)
  );

  assert_read_follows_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (scan_do == $past(state_q[addr_q])));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_int_n |-> (state_q == '0) && !scan_do);

endmodule

// File: tb/ras_array_bench.sv
module ras_array_bench;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         test_mode = 1'b0;
  logic         addr_shift = 1'b0;
  logic         addr_si = 1'b0;
  logic         scan_wr = 1'b0;
  logic         scan_di = 1'b0;
  logic         capture = 1'b0;
  logic [N-1:0] next_state = '0;
  logic         scan_do;
  logic [N-1:0] state_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] exp_state = '0;
  logic [3:0]   exp_addr  = '0;

  typedef struct { logic val; string req; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  ras_array u_ras_array (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .addr_shift(addr_shift),
    .addr_si(addr_si), .scan_wr(scan_wr), .scan_di(scan_di), .scan_do(scan_do),
    .capture(capture), .next_state(next_state), .state_q(state_q)
  );

  // monitor: compares scan_do 5 ns after each edge against queued expectations
  always begin
    @(posedge clk);
    #5;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (scan_do !== it.val) begin
        fails++;
        $display("FAIL %s: scan_do actual %b expected %b", it.req, scan_do, it.val);
      end
    end
  end

  task automatic check_state(input string req);
    checks++;
    if (state_q !== exp_state) begin
      fails++;
      $display("FAIL %s: state_q actual %h expected %h", req, state_q, exp_state);
    end
  endtask

  task automatic shift_bits(input logic [3:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      test_mode = 1'b1; addr_shift = 1'b1; addr_si = val[i];
      @(negedge clk);
      exp_addr = {exp_addr[2:0], val[i]};
    end
    addr_shift = 1'b0;
  endtask

  task automatic write_bit(input logic d);
    test_mode = 1'b1; scan_wr = 1'b1; scan_di = d;
    @(negedge clk);
    scan_wr = 1'b0;
    exp_state[exp_addr] = d;
  endtask

  task automatic read_check(input string req);
    addr_shift = 1'b0; scan_wr = 1'b0; capture = 1'b0;
    sb_q.push_back('{val: exp_state[exp_addr], req: req});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int ops;
    logic [N-1:0] target;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    check_state("R1");
    test_mode = 1'b1;
    read_check("R1");

    // R2 / R5: full address 5, write 1
    shift_bits(4'd5, 4);
    write_bit(1'b1);
    check_state("R5");
    read_check("R6");

    // R9: one extra shift of 1 -> address 11
    shift_bits(4'b0001, 1);
    write_bit(1'b1);
    check_state("R9");
    read_check("R9");

    // R3: idle cycles keep address 11
    repeat (3) @(negedge clk);
    read_check("R3");

    // R4: row/column corners
    shift_bits(4'd12, 4);
    write_bit(1'b1);
    shift_bits(4'd3, 4);
    write_bit(1'b1);
    check_state("R4");
    read_check("R4");

    // R8: scan_wr in normal mode has no effect
    test_mode = 1'b0; scan_wr = 1'b1; scan_di = 1'b0;
    @(negedge clk);
    scan_wr = 1'b0;
    check_state("R8");
    // R3: addr_shift in normal mode has no effect (address stays 3)
    addr_shift = 1'b1; addr_si = 1'b0;
    @(negedge clk);
    addr_shift = 1'b0;
    test_mode = 1'b1;
    read_check("R3");
    // R8: capture in test mode has no effect
    next_state = 16'h0000; capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    check_state("R8");

    // R7: parallel capture
    test_mode = 1'b0; next_state = 16'hA5C3; capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    exp_state = 16'hA5C3;
    check_state("R7");
    test_mode = 1'b1;
    read_check("R7");

    // R10: apply pattern by writing only differing cells
    target = 16'h0F0F;
    ops = 0;
    for (int i = 0; i < N; i++) begin
      if (exp_state[i] != target[i]) begin
        shift_bits(4'(i), 4);
        write_bit(target[i]);
        ops++;
      end
    end
    checks++;
    if (ops != $countones(16'hA5C3 ^ target)) begin
      fails++;
      $display("FAIL R10: writes actual %0d expected %0d", ops, $countones(16'hA5C3 ^ target));
    end
    exp_state = target;
    check_state("R10");

    // R6 / R2: sweep every address
    for (int i = 0; i < N; i++) begin
      shift_bits(4'(i), 4);
      read_check("R6");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule